// File: doc/BRIEF.md
# Stream-Tagged Cache Replacement Controller

This block holds the tags, recency order and line flags of a 4-way, 16-set last-level cache with 64-byte lines. It decides hit or miss and, on a miss, which way to replace. Every request carries a 3-bit stream identifier. A small table, loaded through a configuration port, gives each stream one of four policies. The policy decides whether a miss allocates at all and which way is given up. The data array and the memory timing belong to neighbouring blocks. This controller only tells them what to do: the result on the response port, the displaced line on the eviction port, the line to fetch on the fill port, and extra lines to fetch early on the prefetch port.

A request arrives as a line address (byte offset already removed). The low 4 bits of that address select the set and the upper 6 bits form the tag. Results appear one cycle after the request is accepted. A stream may keep its lines resident, let recent lines go first, or thin its footprint so that only one line in four occupies the cache while its three neighbours are fetched ahead.

Top module: `strm_repl_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid`, `fill_valid`, `evict_valid` and `pf_valid` are 0, every line is invalid, and every stream uses policy code 00.
- R2: A request accepted on a rising edge (`req_valid` and `req_ready` both 1) produces exactly one `rsp_valid` pulse in the following cycle. On a tag match with a valid line, `rsp_hit` is 1 and `rsp_way` gives the matching way.
- R3: Under policy code 00 (least-recent), a miss allocates the lowest-numbered invalid way if one exists. Otherwise it allocates the valid unpinned way that was used longest ago. A displaced valid line appears on `evict_valid`/`evict_line` as {tag, set}, and `evict_dirty` is 1 if the line was written while resident.
- R4: Every hit and every allocation makes the touched way the most recent in its set, under every policy.
- R5: A line allocated under policy code 01 (pinned) is never chosen for replacement by any stream. A hit on it still makes it the most recent in the recency order.
- R6: Under policy code 10 (streaming), a miss in a set with no invalid way replaces the valid unpinned way that was used most recently.
- R7: Under policy code 11 (thinned), a miss allocates only when line address bits [1:0] are 00. Other misses leave the set unchanged, and a repeat of such a request misses again.
- R8: A thinned allocating miss issues `pf_valid` on three consecutive cycles starting one cycle after acceptance, carrying line addresses +1, +2 and +3. `req_ready` is 0 during those cycles.
- R9: If no way qualifies (all four ways pinned, or a thinned skip), the miss is a bypass: `fill_alloc` is 0 and `evict_valid` is 0.
- R10: A policy write on the configuration port applies to requests accepted from the next cycle onward. A request accepted in the same cycle as the write uses the old policy.
- R11: Every miss raises `fill_valid` with `fill_line` equal to the request line and `fill_alloc` showing whether a way was allocated. A hit raises no fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_line | input | 10 | Line address {tag, set} |
| req_sid | input | 3 | Stream identifier |
| req_write | input | 1 | Request is a write |
| cfg_we | input | 1 | Policy table write enable |
| cfg_sid | input | 3 | Stream whose policy is written |
| cfg_pol | input | 2 | Policy code 00/01/10/11 |
| rsp_valid | output | 1 | Result valid |
| rsp_hit | output | 1 | Request hit |
| rsp_way | output | 2 | Hit way or allocated way (0 on bypass) |
| evict_valid | output | 1 | A valid line was displaced |
| evict_line | output | 10 | Line address of displaced line |
| evict_dirty | output | 1 | Displaced line was written |
| fill_valid | output | 1 | Memory fill request |
| fill_line | output | 10 | Line to fetch |
| fill_alloc | output | 1 | Fill is installed in the cache |
| pf_valid | output | 1 | Prefetch request |
| pf_line | output | 10 | Line to prefetch |

## Verification
The hardest state to reach is a set where pinned and unpinned lines are mixed and the pinned line is the oldest. The stimulus fills one set with one pinned line followed by three ordinary lines. It then checks that the next miss skips the oldest line and takes the next oldest. A hit then refreshes the pinned line and the choice is checked once more. The same-cycle configuration rule is exercised by issuing a policy write and a request together in one set. A later miss from another stream then shows, through its eviction address, which lines were installed pinned.

// File: rtl/strm_repl_pkg.sv
package strm_repl_pkg;
  typedef enum logic [1:0] {
    POL_LRU    = 2'b00,
    POL_PIN    = 2'b01,
    POL_STREAM = 2'b10,
    POL_THIN   = 2'b11
  } pol_e;
endpackage

// File: rtl/strm_pol_table.sv
module strm_pol_table
  import strm_repl_pkg::*;
#(
  parameter int SIDS = 8,
  localparam int SID_W = $clog2(SIDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [SID_W-1:0] wsid,
  input  logic [1:0]       wpol,
  input  logic [SID_W-1:0] rsid,
  output pol_e             rpol
);
  logic [1:0] tab_q [SIDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SIDS; i++) tab_q[i] <= 2'b00;
    end else if (we) begin
      tab_q[wsid] <= wpol;
    end
  end

  assign rpol = pol_e'(tab_q[rsid]);
endmodule

// File: rtl/strm_victim_pick.sv
module strm_victim_pick #(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]             vld,
  input  logic [WAYS-1:0]             pin,
  input  logic [WAYS-1:0][WAY_W-1:0]  age,
  input  logic                        want_mru,
  output logic                        found,
  output logic [WAY_W-1:0]            way
);
  logic             inv_hit;
  logic [WAY_W-1:0] inv_way;
  logic             cand;
  logic [WAY_W-1:0] cand_way;
  logic [WAY_W-1:0] best;

  always_comb begin
    inv_hit  = 1'b0;
    inv_way  = '0;
    cand     = 1'b0;
    cand_way = '0;
    best     = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!vld[w] && !inv_hit) begin
        inv_hit = 1'b1;
        inv_way = WAY_W'(w);
      end
    end
    for (int w = 0; w < WAYS; w++) begin
      if (vld[w] && !pin[w]) begin
        if (!cand || (want_mru ? (age[w] < best) : (age[w] > best))) begin
          cand     = 1'b1;
          best     = age[w];
          cand_way = WAY_W'(w);
        end
      end
    end
    found = inv_hit || cand;
    way   = inv_hit ? inv_way : cand_way;
  end
endmodule

// File: rtl/strm_pf_seq.sv
module strm_pf_seq #(
  parameter int LINE_W = 10,
  parameter int PF_N   = 3,
  localparam int CNT_W = $clog2(PF_N + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LINE_W-1:0] base_line,
  output logic              busy,
  output logic              pf_valid,
  output logic [LINE_W-1:0] pf_line
);
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [LINE_W-1:0] line_q, line_d;
  logic              line_en;

  always_comb begin
    cnt_d   = cnt_q;
    line_d  = line_q;
    line_en = 1'b0;
    if (start) begin
      cnt_d   = CNT_W'(PF_N);
      line_d  = base_line + LINE_W'(1);
      line_en = 1'b1;
    end else if (cnt_q != '0) begin
      cnt_d   = cnt_q - CNT_W'(1);
      line_d  = line_q + LINE_W'(1);
      line_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      line_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (line_en) line_q <= line_d;
    end
  end

  assign busy     = (cnt_q != '0);
  assign pf_valid = busy;
  assign pf_line  = line_q;
endmodule

// File: rtl/strm_repl_ctrl.sv
module strm_repl_ctrl
  import strm_repl_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int LINE_BYTES = 64,
  parameter int WAYS       = 4,
  parameter int SETS       = 16,
  parameter int SIDS       = 8,
  parameter int THIN       = 4,
  localparam int OFS_W  = $clog2(LINE_BYTES),
  localparam int LINE_W = ADDR_W - OFS_W,
  localparam int SET_W  = $clog2(SETS),
  localparam int TAG_W  = LINE_W - SET_W,
  localparam int WAY_W  = $clog2(WAYS),
  localparam int SID_W  = $clog2(SIDS),
  localparam int THIN_W = $clog2(THIN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [LINE_W-1:0] req_line,
  input  logic [SID_W-1:0]  req_sid,
  input  logic              req_write,
  input  logic              cfg_we,
  input  logic [SID_W-1:0]  cfg_sid,
  input  logic [1:0]        cfg_pol,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [WAY_W-1:0]  rsp_way,
  output logic              evict_valid,
  output logic [LINE_W-1:0] evict_line,
  output logic              evict_dirty,
  output logic              fill_valid,
  output logic [LINE_W-1:0] fill_line,
  output logic              fill_alloc,
  output logic              pf_valid,
  output logic [LINE_W-1:0] pf_line
);
  // line state, one row per set
  logic [WAYS-1:0]             vld_q [SETS];
  logic [WAYS-1:0]             pin_q [SETS];
  logic [WAYS-1:0]             drt_q [SETS];
  logic [WAYS-1:0][TAG_W-1:0]  tag_q [SETS];
  logic [WAYS-1:0][WAY_W-1:0]  age_q [SETS];

  logic [WAYS-1:0]             vld_d, pin_d, drt_d;
  logic [WAYS-1:0][TAG_W-1:0]  tag_d;
  logic [WAYS-1:0][WAY_W-1:0]  age_d;

  logic              acc, pf_busy;
  logic [SET_W-1:0]  set;
  logic [TAG_W-1:0]  tag;
  pol_e              pol;
  logic [WAYS-1:0]   hit_vec;
  logic              hit;
  logic [WAY_W-1:0]  hit_way, vic_way, touch_way, touch_age;
  logic              vic_found, thin_skip, alloc, touch;

  assign req_ready = !pf_busy;
  assign acc       = req_valid && req_ready;
  assign set       = req_line[SET_W-1:0];
  assign tag       = req_line[LINE_W-1:SET_W];

  strm_pol_table #(.SIDS(SIDS)) u_tab (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wsid(cfg_sid), .wpol(cfg_pol),
    .rsid(req_sid), .rpol(pol)
  );

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = vld_q[set][w] && (tag_q[set][w] == tag);
  end

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) if (hit_vec[w]) hit_way = WAY_W'(w);
  end
  assign hit = |hit_vec;

  strm_victim_pick #(.WAYS(WAYS)) u_pick (
    .vld(vld_q[set]), .pin(pin_q[set]), .age(age_q[set]),
    .want_mru(pol == POL_STREAM), .found(vic_found), .way(vic_way)
  );

  assign thin_skip = (pol == POL_THIN) && (req_line[THIN_W-1:0] != '0);
  assign alloc     = !hit && !thin_skip && vic_found;
  assign touch     = acc && (hit || alloc);
  assign touch_way = hit ? hit_way : vic_way;
  assign touch_age = age_q[set][touch_way];

  // next row for the addressed set
  always_comb begin
    vld_d = vld_q[set];
    pin_d = pin_q[set];
    drt_d = drt_q[set];
    tag_d = tag_q[set];
    for (int w = 0; w < WAYS; w++) begin
      if (WAY_W'(w) == touch_way)         age_d[w] = '0;
      else if (age_q[set][w] < touch_age) age_d[w] = age_q[set][w] + WAY_W'(1);
      else                                age_d[w] = age_q[set][w];
    end
    if (alloc) begin
      vld_d[vic_way] = 1'b1;
      pin_d[vic_way] = (pol == POL_PIN);
      drt_d[vic_way] = req_write;
      tag_d[vic_way] = tag;
    end else if (hit && req_write) begin
      drt_d[hit_way] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        pin_q[s] <= '0;
        drt_q[s] <= '0;
        tag_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
      end
    end else if (touch) begin
      vld_q[set] <= vld_d;
      pin_q[set] <= pin_d;
      drt_q[set] <= drt_d;
      tag_q[set] <= tag_d;
      age_q[set] <= age_d;
    end
  end

  strm_pf_seq #(.LINE_W(LINE_W), .PF_N(THIN - 1)) u_pf (
    .clk(clk), .rst_n(rst_n), .start(acc && alloc && (pol == POL_THIN)),
    .base_line(req_line), .busy(pf_busy), .pf_valid(pf_valid), .pf_line(pf_line)
  );

  // result registers
  logic              ev_d;
  logic [WAY_W-1:0]  way_d;
  assign ev_d  = alloc && vld_q[set][vic_way];
  assign way_d = hit ? hit_way : (alloc ? vic_way : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      evict_valid <= 1'b0;
      fill_valid  <= 1'b0;
      rsp_hit     <= 1'b0;
      rsp_way     <= '0;
      evict_line  <= '0;
      evict_dirty <= 1'b0;
      fill_line   <= '0;
      fill_alloc  <= 1'b0;
    end else begin
      rsp_valid   <= acc;
      evict_valid <= acc && ev_d;
      fill_valid  <= acc && !hit;
      if (acc) begin
        rsp_hit     <= hit;
        rsp_way     <= way_d;
        evict_line  <= {tag_q[set][vic_way], set};
        evict_dirty <= ev_d && drt_q[set][vic_way];
        fill_line   <= req_line;
        fill_alloc  <= alloc;
      end
    end
  end
endmodule

// File: rtl/strm_repl_chk.sv
module strm_repl_chk #(
  parameter int LINE_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic              fill_valid,
  input logic              fill_alloc,
  input logic              evict_valid,
  input logic              pf_valid,
  input logic [LINE_W-1:0] pf_line
);
  // R2
  rsp_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && req_ready));
  // R11
  miss_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> fill_valid);
  // R11
  fill_only_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> (rsp_valid && !rsp_hit));
  // R9
  evict_needs_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evict_valid |-> (fill_valid && fill_alloc));
  // R8
  pf_stalls_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> !req_ready);
  // R8
  pf_stride_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && $past(pf_valid)) |-> (pf_line == $past(pf_line) + LINE_W'(1)));
endmodule

bind strm_repl_ctrl strm_repl_chk #(.LINE_W(LINE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .fill_valid(fill_valid),
  .fill_alloc(fill_alloc), .evict_valid(evict_valid), .pf_valid(pf_valid),
  .pf_line(pf_line)
);

// File: tb/sim_strm_repl_ctrl.sv
`timescale 1ns/1ps
module sim_strm_repl_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, cfg_we = 1'b0;
  logic [9:0] req_line = '0;
  logic [2:0] req_sid = '0, cfg_sid = '0;
  logic [1:0] cfg_pol = '0;
  logic req_ready, rsp_valid, rsp_hit, evict_valid, evict_dirty;
  logic fill_valid, fill_alloc, pf_valid;
  logic [1:0] rsp_way;
  logic [9:0] evict_line, fill_line, pf_line;

  always #10 clk = ~clk;

  strm_repl_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_line(req_line), .req_sid(req_sid), .req_write(req_write),
    .cfg_we(cfg_we), .cfg_sid(cfg_sid), .cfg_pol(cfg_pol),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way),
    .evict_valid(evict_valid), .evict_line(evict_line), .evict_dirty(evict_dirty),
    .fill_valid(fill_valid), .fill_line(fill_line), .fill_alloc(fill_alloc),
    .pf_valid(pf_valid), .pf_line(pf_line)
  );

  typedef struct {
    bit hit; int way; bit alloc; bit ev; logic [9:0] evl; bit evd;
    logic [9:0] line; string req;
  } exp_t;
  exp_t sb[$];
  logic [9:0] pfq[$];
  int nchk = 0, nfail = 0;
  bit done = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [9:0] ln(int t, int s);
    return {t[5:0], s[3:0]};
  endfunction

  // monitor: compare results against scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rsp_valid) begin
        if (sb.size() == 0) chk(0, "R2", "unexpected response", 1, 0);
        else begin
          exp_t e;
          e = sb.pop_front();
          chk(rsp_hit == e.hit, e.req, "rsp_hit", rsp_hit, e.hit);
          if (e.way >= 0) chk(rsp_way == e.way, e.req, "rsp_way", rsp_way, e.way);
          chk(fill_valid == !e.hit, "R11", "fill_valid", fill_valid, !e.hit);
          chk(fill_alloc == e.alloc, e.req, "fill_alloc", fill_alloc, e.alloc);
          if (!e.hit) chk(fill_line == e.line, "R11", "fill_line", fill_line, e.line);
          chk(evict_valid == e.ev, e.req, "evict_valid", evict_valid, e.ev);
          if (e.ev) begin
            chk(evict_line == e.evl, e.req, "evict_line", evict_line, e.evl);
            chk(evict_dirty == e.evd, e.req, "evict_dirty", evict_dirty, e.evd);
          end
        end
      end
      if (pf_valid) begin
        chk(!req_ready, "R8", "req_ready during prefetch", req_ready, 0);
        if (pfq.size() == 0) chk(0, "R8", "unexpected prefetch", pf_line, 0);
        else begin
          logic [9:0] p;
          p = pfq.pop_front();
          chk(pf_line == p, "R8", "pf_line", pf_line, p);
        end
      end
    end
  end

  task automatic access(logic [9:0] line, int sid, bit wr, bit hit, int way,
                        bit alloc, bit ev, logic [9:0] evl, bit evd, string req,
                        bit cfg = 0, int csid = 0, int cpol = 0);
    exp_t e;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    e.hit = hit; e.way = way; e.alloc = alloc; e.ev = ev; e.evl = evl;
    e.evd = evd; e.line = line; e.req = req;
    sb.push_back(e);
    req_valid = 1'b1; req_line = line; req_sid = 3'(sid); req_write = wr;
    cfg_we = cfg; cfg_sid = 3'(csid); cfg_pol = 2'(cpol);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; cfg_we = 1'b0;
  endtask

  task automatic set_pol(int sid, int pol);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sid = 3'(sid); cfg_pol = 2'(pol);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic summary();
    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready == 1, "R1", "req_ready", req_ready, 1);
    chk(rsp_valid == 0, "R1", "rsp_valid", rsp_valid, 0);
    chk(pf_valid == 0, "R1", "pf_valid", pf_valid, 0);
    chk(fill_valid == 0 && evict_valid == 0, "R1", "fill/evict", fill_valid, 0);

    // R3/R4 least-recent policy in set 1
    access(ln(1,1), 0, 0, 0, 0, 1, 0, 0, 0, "R1");
    access(ln(2,1), 0, 0, 0, 1, 1, 0, 0, 0, "R3");
    access(ln(3,1), 0, 1, 0, 2, 1, 0, 0, 0, "R3");
    access(ln(4,1), 0, 0, 0, 3, 1, 0, 0, 0, "R3");
    access(ln(1,1), 0, 0, 1, 0, 0, 0, 0, 0, "R2");
    access(ln(5,1), 0, 0, 0, 1, 1, 1, ln(2,1), 0, "R4");
    access(ln(6,1), 0, 0, 0, 2, 1, 1, ln(3,1), 1, "R3");

    // R6 streaming in set 2
    set_pol(2, 2);
    access(ln(1,2), 2, 0, 0, 0, 1, 0, 0, 0, "R6");
    access(ln(2,2), 2, 0, 0, 1, 1, 0, 0, 0, "R6");
    access(ln(3,2), 2, 0, 0, 2, 1, 0, 0, 0, "R6");
    access(ln(4,2), 2, 0, 0, 3, 1, 0, 0, 0, "R6");
    access(ln(5,2), 2, 0, 0, 3, 1, 1, ln(4,2), 0, "R6");
    access(ln(6,2), 2, 0, 0, 3, 1, 1, ln(5,2), 0, "R6");

    // R5/R9 all pinned in set 3
    set_pol(1, 1);
    access(ln(1,3), 1, 0, 0, 0, 1, 0, 0, 0, "R5");
    access(ln(2,3), 1, 0, 0, 1, 1, 0, 0, 0, "R5");
    access(ln(3,3), 1, 0, 0, 2, 1, 0, 0, 0, "R5");
    access(ln(4,3), 1, 0, 0, 3, 1, 0, 0, 0, "R5");
    access(ln(5,3), 1, 0, 0, 0, 0, 0, 0, 0, "R9");
    access(ln(6,3), 0, 0, 0, 0, 0, 0, 0, 0, "R9");
    access(ln(1,3), 0, 0, 1, 0, 0, 0, 0, 0, "R5");

    // R5 mixed set 4: pinned oldest line is skipped
    access(ln(1,4), 1, 0, 0, 0, 1, 0, 0, 0, "R5");
    access(ln(2,4), 0, 0, 0, 1, 1, 0, 0, 0, "R5");
    access(ln(3,4), 0, 0, 0, 2, 1, 0, 0, 0, "R5");
    access(ln(4,4), 0, 0, 0, 3, 1, 0, 0, 0, "R5");
    access(ln(5,4), 0, 0, 0, 1, 1, 1, ln(2,4), 0, "R5");
    access(ln(1,4), 0, 0, 1, 0, 0, 0, 0, 0, "R4");
    access(ln(6,4), 0, 0, 0, 2, 1, 1, ln(3,4), 0, "R5");

    // R7/R8 thinned stream 3
    set_pol(3, 3);
    access(ln(7,5), 3, 0, 0, 0, 0, 0, 0, 0, "R7");
    access(ln(7,5), 3, 0, 0, 0, 0, 0, 0, 0, "R7");
    pfq.push_back(ln(7,8) + 10'd1);
    pfq.push_back(ln(7,8) + 10'd2);
    pfq.push_back(ln(7,8) + 10'd3);
    access(ln(7,8), 3, 0, 0, 0, 1, 0, 0, 0, "R8");
    access(ln(7,8), 3, 0, 1, 0, 0, 0, 0, 0, "R7");

    // R10 same-cycle config write uses old policy (set 6)
    access(ln(1,6), 4, 0, 0, 0, 1, 0, 0, 0, "R10", 1, 4, 1);
    access(ln(2,6), 4, 0, 0, 1, 1, 0, 0, 0, "R10");
    access(ln(3,6), 4, 0, 0, 2, 1, 0, 0, 0, "R10");
    access(ln(4,6), 4, 0, 0, 3, 1, 0, 0, 0, "R10");
    access(ln(5,6), 0, 0, 0, 0, 1, 1, ln(1,6), 0, "R10");

    repeat (6) @(negedge clk);
    chk(sb.size() == 0, "R2", "responses outstanding", sb.size(), 0);
    chk(pfq.size() == 0, "R8", "prefetches outstanding", pfq.size(), 0);
    summary();
  end
endmodule